// File: doc/BRIEF.md
# Transmit Queue Channel Steering Scheduler

This block keeps a set of circular transmit descriptor queues and chooses which pending descriptor goes out next. Each queue is bound by configuration to one of a small set of DMA channels, and several queues may feed the same channel. The channels have fixed roles. Data channels 0 to 3 carry background, best-effort, video and voice/management traffic, in rising order of precedence. Channel 7 carries commands and outranks every data channel. Channels 4 to 6 are unused and never receive a grant.

Software programs each queue through a narrow register-style port. One write kind sets the queue's channel and active flag. The other write kind moves the queue's write pointer. The block keeps the read pointer of every queue. When a grant is taken, the block presents the queue number, the descriptor slot (the current read pointer) and the channel on a valid/ready port. When the channel side accepts the grant, the read pointer of that queue moves up by one.

The control is a two-state machine.
- SCAN: the priority and round-robin logic look for an eligible queue. The transition SCAN→OFFER is taken in any cycle in which one is found, and the grant is captured into registers.
- OFFER: the captured grant is presented with valid high and held unchanged. The transition OFFER→SCAN is taken on the cycle the ready input is high.

Top module: `txq_steer`

## Requirements
- R1: After reset, no grant is offered, every queue is inactive, and all read and write pointers are zero.
- R2: A write with `cfg_kind`=0 sets a queue's status: `cfg_wdata[2:0]` is the channel and `cfg_wdata[3]` is the active flag. A write with `cfg_kind`=1 sets the queue's write pointer to `cfg_wdata`. A queue whose active flag is 0 is never granted, whatever its pointers hold.
- R3: A queue has pending descriptors while its write pointer differs from its read pointer. Each grant reports the queue's read pointer as `gnt_desc`, and an empty queue is never granted.
- R4: Among eligible queues, channel 7 wins first, then channels 3, 2, 1 and 0 in that order.
- R5: A queue bound to channel 4, 5 or 6 is never granted, and `gnt_chan` is never 4, 5 or 6 while `gnt_valid` is high.
- R6: Eligible queues on the same channel are served round-robin in ascending queue order, starting after the queue last accepted on that channel. After reset, the search starts from queue 0.
- R7: A queue's read pointer advances by exactly one, modulo 256, on each cycle with `gnt_valid` and `gnt_ready` both high, and at no other time.
- R8: Once offered, a grant stays valid with unchanged queue, descriptor and channel until it is accepted. This holds even if its queue is deactivated meanwhile. After that grant is accepted, a deactivated queue gets no further grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0: status write, 1: write-pointer write |
| cfg_queue | input | 4 | Queue addressed by the write |
| cfg_wdata | input | 8 | Write data (status field or pointer) |
| gnt_valid | output | 1 | A grant is offered |
| gnt_ready | input | 1 | Channel side accepts the offered grant |
| gnt_queue | output | 4 | Queue of the offered grant |
| gnt_desc | output | 8 | Descriptor slot of the offered grant |
| gnt_chan | output | 3 | Target channel of the offered grant |

## Verification
The bench builds the block with its default parameters: 16 queues, 8-bit pointers, 8 channel slots, command channel 7 and four data channels. With these values, a single queue can wrap its read pointer from 255 to 0 inside the run. With these values, three queues can share one channel to show the round-robin order. With these values, one queue parked on an unused channel stays pending for the whole run. The scoreboard holds grants back with a low ready while queues are activated one by one. This makes the priority order, the hold of a deactivated grant, and the arbitration order all deterministic.

// File: rtl/txq_steer_pkg.sv
package txq_steer_pkg;

    typedef enum logic [0:0] {
        ST_SCAN  = 1'b0,
        ST_OFFER = 1'b1
    } steer_state_e;

    // Status field layout seen by software
    localparam int STAT_CHAN_W   = 3;
    localparam int STAT_ACT_BIT  = 3;

endpackage

// File: rtl/txq_steer_ptrs.sv
module txq_steer_ptrs #(
    parameter int NQ = 16,
    parameter int QW = 4,
    parameter int PW = 8,
    parameter int CW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_kind,
    input  logic [QW-1:0]          cfg_queue,
    input  logic [PW-1:0]          cfg_wdata,
    input  logic                   adv_en,
    input  logic [QW-1:0]          adv_q,
    output logic [NQ-1:0]          q_active,
    output logic [NQ-1:0][CW-1:0]  q_chan,
    output logic [NQ-1:0][PW-1:0]  q_wr,
    output logic [NQ-1:0][PW-1:0]  q_rd
);
    import txq_steer_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_active <= '0;
            q_chan   <= '0;
            q_wr     <= '0;
        end else if (cfg_we) begin
            if (!cfg_kind) begin
                q_active[cfg_queue] <= cfg_wdata[STAT_ACT_BIT];
                q_chan[cfg_queue]   <= cfg_wdata[CW-1:0];
            end else begin
                q_wr[cfg_queue] <= cfg_wdata;
            end
        end
    end

    // Hardware-owned read pointers, wrap naturally at 2**PW
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rd <= '0;
        end else if (adv_en) begin
            q_rd[adv_q] <= q_rd[adv_q] + 1'b1;
        end
    end

    assert_rd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(q_rd));

    assert_rd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> q_rd[$past(adv_q)] == PW'($past(q_rd[adv_q]) + 1'b1));

endmodule

// File: rtl/txq_steer_rr.sv
module txq_steer_rr #(
    parameter int NQ = 16,
    parameter int QW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] req,
    input  logic          upd,
    input  logic [QW-1:0] upd_q,
    output logic          hit,
    output logic [QW-1:0] sel_q
);
    logic [QW-1:0] last_q;
    int            idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= QW'(NQ - 1);
        end else if (upd) begin
            last_q <= upd_q;
        end
    end

    // Search in ascending order starting just after the last winner
    always_comb begin
        hit   = 1'b0;
        sel_q = '0;
        idx   = 0;
        for (int i = 1; i <= NQ; i++) begin
            idx = (int'(last_q) + i) % NQ;
            if (!hit && req[idx]) begin
                hit   = 1'b1;
                sel_q = QW'(idx);
            end
        end
    end

    assert_rr_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> req[sel_q]);

    assert_rr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !hit);

endmodule

// File: rtl/txq_steer.sv
module txq_steer #(
    parameter int NQ     = 16,
    parameter int PW     = 8,
    parameter int NCH    = 8,
    parameter int CMD_CH = 7,
    parameter int NDATA  = 4,
    localparam int QW    = $clog2(NQ),
    localparam int CW    = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_kind,
    input  logic [QW-1:0] cfg_queue,
    input  logic [PW-1:0] cfg_wdata,
    output logic          gnt_valid,
    input  logic          gnt_ready,
    output logic [QW-1:0] gnt_queue,
    output logic [PW-1:0] gnt_desc,
    output logic [CW-1:0] gnt_chan
);
    import txq_steer_pkg::*;

    steer_state_e state_q, state_d;

    logic [NQ-1:0]          q_active;
    logic [NQ-1:0][CW-1:0]  q_chan;
    logic [NQ-1:0][PW-1:0]  q_wr;
    logic [NQ-1:0][PW-1:0]  q_rd;
    logic [NQ-1:0]          eligible;
    logic [NCH-1:0]         chan_hit;
    logic [NCH-1:0][QW-1:0] chan_sel;
    logic                   pick_hit;
    logic [QW-1:0]          pick_q;
    logic [CW-1:0]          pick_ch;
    logic [QW-1:0]          off_q;
    logic [PW-1:0]          off_desc;
    logic [CW-1:0]          off_ch;
    logic                   accept;

    assign accept = gnt_valid && gnt_ready;

    txq_steer_ptrs #(.NQ(NQ), .QW(QW), .PW(PW), .CW(CW)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_queue (cfg_queue),
        .cfg_wdata (cfg_wdata),
        .adv_en    (accept),
        .adv_q     (off_q),
        .q_active  (q_active),
        .q_chan    (q_chan),
        .q_wr      (q_wr),
        .q_rd      (q_rd)
    );

    // A queue competes only when active, non-empty and bound to a used channel
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            eligible[q] = q_active[q] && (q_wr[q] != q_rd[q]) &&
                          ((int'(q_chan[q]) < NDATA) || (int'(q_chan[q]) == CMD_CH));
        end
    end

    // One round-robin picker per used channel slot
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        if (c < NDATA || c == CMD_CH) begin : g_used
            logic [NQ-1:0] req_c;
            always_comb begin
                for (int q = 0; q < NQ; q++) begin
                    req_c[q] = eligible[q] && (q_chan[q] == CW'(c));
                end
            end
            txq_steer_rr #(.NQ(NQ), .QW(QW)) u_rr (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req_c),
                .upd   (accept && (off_ch == CW'(c))),
                .upd_q (off_q),
                .hit   (chan_hit[c]),
                .sel_q (chan_sel[c])
            );
        end else begin : g_unused
            assign chan_hit[c] = 1'b0;
            assign chan_sel[c] = '0;
        end
    end

    // Fixed channel precedence: command slot, then data slots high to low
    always_comb begin
        pick_hit = 1'b0;
        pick_q   = '0;
        pick_ch  = '0;
        if (chan_hit[CMD_CH]) begin
            pick_hit = 1'b1;
            pick_q   = chan_sel[CMD_CH];
            pick_ch  = CW'(CMD_CH);
        end else begin
            for (int c = NDATA - 1; c >= 0; c--) begin
                if (!pick_hit && chan_hit[c]) begin
                    pick_hit = 1'b1;
                    pick_q   = chan_sel[c];
                    pick_ch  = CW'(c);
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:  if (pick_hit)  state_d = ST_OFFER;
            ST_OFFER: if (gnt_ready) state_d = ST_SCAN;
            default:                 state_d = ST_SCAN;
        endcase
    end

    // Grant capture in SCAN; frozen through OFFER
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= '0;
            off_desc <= '0;
            off_ch   <= '0;
        end else if (state_q == ST_SCAN && pick_hit) begin
            off_q    <= pick_q;
            off_desc <= q_rd[pick_q];
            off_ch   <= pick_ch;
        end
    end

    // Outputs
    always_comb begin
        gnt_valid = (state_q == ST_OFFER);
        gnt_queue = off_q;
        gnt_desc  = off_desc;
        gnt_chan  = off_ch;
    end

    assert_legal_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ((int'(gnt_chan) < NDATA) || (int'(gnt_chan) == CMD_CH)));

    assert_hold_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_queue) &&
                                       $stable(gnt_desc) && $stable(gnt_chan)));

    assert_cmd_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && chan_hit[CMD_CH]) |=> (gnt_valid && int'(gnt_chan) == CMD_CH));

    assert_offer_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> (q_wr[gnt_queue] != q_rd[gnt_queue]));

endmodule

// File: tb/test_txq_steer.sv
module test_txq_steer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic       cfg_kind;
    logic [3:0] cfg_queue;
    logic [7:0] cfg_wdata;
    logic       gnt_valid;
    logic       gnt_ready;
    logic [3:0] gnt_queue;
    logic [7:0] gnt_desc;
    logic [2:0] gnt_chan;

    int vecs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    int    eq_q[$];
    int    eq_d[$];
    int    eq_c[$];
    string eq_tag[$];

    always #10 clk = ~clk;

    txq_steer i_txq_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_queue (cfg_queue),
        .cfg_wdata (cfg_wdata),
        .gnt_valid (gnt_valid),
        .gnt_ready (gnt_ready),
        .gnt_queue (gnt_queue),
        .gnt_desc  (gnt_desc),
        .gnt_chan  (gnt_chan)
    );

    task automatic expect_grant(input int q, input int d, input int c, input string tag);
        eq_q.push_back(q);
        eq_d.push_back(d);
        eq_c.push_back(c);
        eq_tag.push_back(tag);
    endtask

    task automatic cfg_write(input bit kind, input int q, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_kind  = kind;
        cfg_queue = 4'(q);
        cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Monitor: compare every accepted grant against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #8;
            if (rst_n === 1'b1 && gnt_valid && gnt_ready) begin
                vecs++;
                if (eq_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2/R5 unexpected grant q=%0d d=%0d ch=%0d, expected none",
                             gnt_queue, gnt_desc, gnt_chan);
                end else begin
                    automatic int    xq = eq_q.pop_front();
                    automatic int    xd = eq_d.pop_front();
                    automatic int    xc = eq_c.pop_front();
                    automatic string xt = eq_tag.pop_front();
                    if (int'(gnt_queue) != xq || int'(gnt_desc) != xd || int'(gnt_chan) != xc) begin
                        fails++;
                        $display("FAIL %s grant q=%0d d=%0d ch=%0d, expected q=%0d d=%0d ch=%0d",
                                 xt, gnt_queue, gnt_desc, gnt_chan, xq, xd, xc);
                    end
                end
            end
        end
    end

    task automatic drain(input string tag);
        int guard;
        guard = 0;
        while (eq_q.size() != 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        vecs++;
        if (eq_q.size() != 0) begin
            fails++;
            $display("FAIL %s scoreboard not drained: %0d left, expected 0", tag, eq_q.size());
            eq_q.delete(); eq_d.delete(); eq_c.delete(); eq_tag.delete();
        end
    endtask

    task automatic check_idle(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #8;
            vecs++;
            if (gnt_valid !== 1'b0) begin
                fails++;
                $display("FAIL %s gnt_valid=%0b q=%0d, expected 0", tag, gnt_valid, gnt_queue);
            end
        end
    endtask

    task automatic check_offer(input int q, input int d, input int c, input string tag);
        @(negedge clk);
        #8;
        vecs++;
        if (gnt_valid !== 1'b1 || int'(gnt_queue) != q || int'(gnt_desc) != d || int'(gnt_chan) != c) begin
            fails++;
            $display("FAIL %s offer v=%0b q=%0d d=%0d ch=%0d, expected v=1 q=%0d d=%0d ch=%0d",
                     tag, gnt_valid, gnt_queue, gnt_desc, gnt_chan, q, d, c);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, expected run to finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_kind  = 1'b0;
        cfg_queue = '0;
        cfg_wdata = '0;
        gnt_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n     = 1'b1;
        gnt_ready = 1'b1;

        // R1: nothing offered after reset
        check_idle(3, "R1");

        // R3: basic service of one queue; first slot 0 shows reset pointer (R1)
        cfg_write(1'b0, 0, 8'h08);
        expect_grant(0, 0, 0, "R3");
        expect_grant(0, 1, 0, "R3");
        cfg_write(1'b1, 0, 2);
        drain("R3");
        check_idle(5, "R3");

        // R2: pending but inactive queue is ignored
        cfg_write(1'b1, 9, 4);
        check_idle(8, "R2");

        // R4 / R5: channel precedence, unused channel never served
        gnt_ready = 1'b0;
        cfg_write(1'b1, 3, 1);
        cfg_write(1'b1, 4, 1);
        cfg_write(1'b1, 6, 1);
        cfg_write(1'b1, 8, 1);
        cfg_write(1'b1, 10, 1);
        cfg_write(1'b1, 11, 1);
        cfg_write(1'b0, 10, 8'h0F);
        check_offer(10, 0, 7, "R4");
        cfg_write(1'b0, 11, 8'h0D);
        cfg_write(1'b0, 3, 8'h08);
        cfg_write(1'b0, 4, 8'h09);
        cfg_write(1'b0, 6, 8'h0A);
        cfg_write(1'b0, 8, 8'h0B);
        check_offer(10, 0, 7, "R4");
        expect_grant(10, 0, 7, "R4");
        expect_grant(8, 0, 3, "R4");
        expect_grant(6, 0, 2, "R4");
        expect_grant(4, 0, 1, "R4");
        expect_grant(3, 0, 0, "R4");
        gnt_ready = 1'b1;
        drain("R4");
        check_idle(10, "R5");

        // R6: round-robin among three queues on channel 1
        gnt_ready = 1'b0;
        cfg_write(1'b1, 12, 2);
        cfg_write(1'b1, 13, 2);
        cfg_write(1'b1, 14, 2);
        cfg_write(1'b0, 12, 8'h09);
        cfg_write(1'b0, 13, 8'h09);
        cfg_write(1'b0, 14, 8'h09);
        for (int d = 0; d < 2; d++) begin
            expect_grant(12, d, 1, "R6");
            expect_grant(13, d, 1, "R6");
            expect_grant(14, d, 1, "R6");
        end
        gnt_ready = 1'b1;
        drain("R6");

        // R8: offered grant survives deactivation, then queue goes quiet
        gnt_ready = 1'b0;
        cfg_write(1'b0, 15, 8'h0A);
        cfg_write(1'b1, 15, 3);
        check_offer(15, 0, 2, "R8");
        cfg_write(1'b0, 15, 8'h02);
        check_offer(15, 0, 2, "R8");
        check_offer(15, 0, 2, "R7");
        expect_grant(15, 0, 2, "R8");
        @(negedge clk);
        gnt_ready = 1'b1;
        @(negedge clk);
        gnt_ready = 1'b0;
        drain("R8");
        gnt_ready = 1'b1;
        check_idle(6, "R8");
        expect_grant(15, 1, 2, "R2");
        expect_grant(15, 2, 2, "R2");
        cfg_write(1'b0, 15, 8'h0A);
        drain("R2");

        // R7: read pointer wraps from 255 to 0
        for (int d = 2; d < 255; d++) expect_grant(0, d, 0, "R7");
        cfg_write(1'b1, 0, 255);
        drain("R7");
        expect_grant(0, 255, 0, "R7");
        expect_grant(0, 0, 0, "R7");
        cfg_write(1'b1, 0, 1);
        drain("R7");
        check_idle(5, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule